// File: doc/BRIEF.md
# Dual Temperature Sensor Serial Port

This block lets a processor talk, one bit at a time, to a pair of three-wire digital thermometers that share a serial clock and a reset line. The processor writes codes to a control register to pulse reset and to move the serial clock low or high. It writes codes to a data-write register that first shift in an 8-bit command and afterwards shift in data bits. Each strobe on the read port returns one bit from each thermometer at once.

Both thermometers are served in lockstep. Read bit i carries the current bit of thermometer i. Each thermometer holds a 9-bit temperature register and an 8-bit configuration register. Both are loaded with fixed values at reset, so software sees a plausible reading without any conversion hardware. The command that is held decides which of the two registers a read walks through, starting at the least significant bit. The shifter clears itself when the last bit has been read.

Top module: `dual_thermo_serial`

## Requirements
- R1: After reset, rdData is 0, no command is held and the clock-low flag is clear, so data-write accesses are ignored until a clock-low code arrives.
- R2: Writing 0x04 to the control register (wrAddr 0) clears the command word and both bit positions. The clock-low flag keeps its value.
- R3: On the control register, 0x02 sets the clock-low flag and 0x01 clears it. While the flag is clear, every data-write access (wrAddr 1) other than 0x80 has no effect.
- R4: Writing 0x80 to the data-write register sets the read bit position to 0 whatever the clock flag is. The held command is not touched.
- R5: While the flag is set and fewer than 8 command bits have arrived, each data-write access shifts one command bit in, least significant bit first. The bit is 1 for value 0x01 and 0 for any other value.
- R6: The command takes effect when its 8th bit arrives. Command 0xEE clears the whole shifter. Command 0xAC (read configuration) and command 0xAA (read temperature) stay held for reading.
- R7: Once a command is complete, each accepted data-write access moves the read bit position on by one.
- R8: A read strobe puts bit p of every thermometer's selected register into rdData bit i, where i is the thermometer index and p is the read bit position. The value appears the cycle after the strobe, the higher bits are 0, and the position then advances by one.
- R9: A read of configuration is 8 bits long and a read of temperature is 9 bits long. The read that returns the last bit also clears the shifter, so any later read returns 0.
- R10: A read strobe while no read command is held returns 0 and changes no state.
- R11: Every temperature register resets to 44 (22 degrees in half-degree steps). Every configuration register resets to 0x8A.
- R12: When a read strobe and a write fall in the same cycle, the read returns the bit from the state before that cycle. The write's effect on the shifter replaces the read's advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 1 | Write target: 0 is control, 1 is data-write |
| wrData | input | 8 | Write value |
| rdEn | input | 1 | Read strobe for the data-read register |
| rdData | output | RD_W (8) | Read result; bit i is thermometer i |

## Verification
A read strobe and a data-write access can land in the same cycle. The read then wants to advance the bit position, while the write wants to rewind it or shift it. The bench provokes this by strobing the read port together with an enable-read write in the middle of a temperature read. It checks two things: the returned bit comes from the position held before that cycle, and the following reads start again from bit 0 rather than from one position further on.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  localparam logic [7:0] CTRL_RESET    = 8'h04;
  localparam logic [7:0] CTRL_CLK_LOW  = 8'h02;
  localparam logic [7:0] CTRL_CLK_HIGH = 8'h01;
  localparam logic [7:0] DW_ENREAD     = 8'h80;
  localparam logic [7:0] DW_HIGH       = 8'h01;
  localparam logic [7:0] CMD_START     = 8'hEE;
  localparam logic [7:0] CMD_RD_CFG    = 8'hAC;
  localparam logic [7:0] CMD_RD_TEMP   = 8'hAA;

  typedef struct packed {
    logic clrAll;
    logic rewind;
    logic shift;
    logic shiftVal;
    logic readStep;
  } strobe_t;
endpackage

// File: rtl/thermo_ctrl.sv
module thermo_ctrl
  import thermo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrAddr,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  output strobe_t    str
);
  logic clkLow;
  logic ctrlWr;
  logic dataWr;

  assign ctrlWr = wrEn && !wrAddr;
  assign dataWr = wrEn && wrAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkLow <= 1'b0;
    end else if (ctrlWr) begin
      if (wrData == CTRL_CLK_LOW)
        clkLow <= 1'b1;
      else if (wrData == CTRL_CLK_HIGH)
        clkLow <= 1'b0;
    end
  end

  always_comb begin
    str          = '0;
    str.clrAll   = ctrlWr && (wrData == CTRL_RESET);
    str.rewind   = dataWr && (wrData == DW_ENREAD);
    str.shift    = dataWr && (wrData != DW_ENREAD) && clkLow;
    str.shiftVal = (wrData == DW_HIGH);
    str.readStep = rdEn;
  end

  p_clk_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData == CTRL_CLK_HIGH) |=> !clkLow);
  p_clk_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData == CTRL_CLK_LOW) |=> clkLow);
endmodule

// File: rtl/thermo_dp.sv
module thermo_dp
  import thermo_pkg::*;
#(
  parameter int SENSORS   = 2,
  parameter int RD_W      = 8,
  parameter int CMD_W     = 8,
  parameter int CFG_LEN   = 8,
  parameter int TEMP_LEN  = 9,
  parameter int TEMP_INIT = 44,
  parameter int CFG_INIT  = 8'h8A
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         str,
  output logic [RD_W-1:0] rdData
);
  localparam int CPOS_W  = $clog2(CMD_W + 1);
  localparam int POS_W   = $clog2(TEMP_LEN) + 1;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [CMD_W-1:0]    cmdWord;
  logic [CMD_W-1:0]    nextCmd;
  logic [CPOS_W-1:0]   cmdPos;
  logic [POS_W-1:0]    dataPos;
  logic [TEMP_LEN-1:0] tempReg [SENSORS];
  logic [CFG_LEN-1:0]  cfgReg  [SENSORS];
  logic                cmdDone, readCfg, readTmp, readValid, lastBit, writeAny;
  logic [POS_W-1:0]    curLen;
  logic [POS_W:0]      posNext;
  logic [RD_W-1:0]     readWord;

  for (genvar g = 0; g < SENSORS; g++) begin : g_sensor
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tempReg[g] <= TEMP_LEN'(TEMP_INIT);
        cfgReg[g]  <= CFG_LEN'(CFG_INIT);
      end else begin
        tempReg[g] <= tempReg[g];
        cfgReg[g]  <= cfgReg[g];
      end
    end
  end

  assign cmdDone   = (cmdPos == CPOS_W'(CMD_W));
  assign readCfg   = cmdDone && (cmdWord == CMD_W'(CMD_RD_CFG));
  assign readTmp   = cmdDone && (cmdWord == CMD_W'(CMD_RD_TEMP));
  assign readValid = readCfg || readTmp;
  assign curLen    = readCfg ? POS_W'(CFG_LEN) : POS_W'(TEMP_LEN);
  assign posNext   = {1'b0, dataPos} + 1'b1;
  assign lastBit   = posNext >= {1'b0, curLen};
  assign writeAny  = str.clrAll || str.rewind || str.shift;
  assign nextCmd   = cmdWord | (CMD_W'(str.shiftVal) << cmdPos);

  always_comb begin
    logic [CFG_LEN-1:0]  cfgSh;
    logic [TEMP_LEN-1:0] tmpSh;
    readWord = '0;
    for (int i = 0; i < SENSORS; i++) begin
      cfgSh = cfgReg[i] >> dataPos;
      tmpSh = tempReg[i] >> dataPos;
      readWord[i] = readCfg ? cfgSh[0] : tmpSh[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdWord <= '0;
      cmdPos  <= '0;
      dataPos <= '0;
    end else if (str.clrAll) begin
      cmdWord <= '0;
      cmdPos  <= '0;
      dataPos <= '0;
    end else if (str.rewind) begin
      dataPos <= '0;
    end else if (str.shift) begin
      if (!cmdDone) begin
        if (cmdPos == CPOS_W'(CMD_W - 1) && nextCmd == CMD_W'(CMD_START)) begin
          cmdWord <= '0;
          cmdPos  <= '0;
          dataPos <= '0;
        end else begin
          cmdWord <= nextCmd;
          cmdPos  <= cmdPos + 1'b1;
        end
      end else if (dataPos != POS_MAX) begin
        dataPos <= dataPos + 1'b1;
      end
    end else if (str.readStep && readValid) begin
      if (lastBit) begin
        cmdWord <= '0;
        cmdPos  <= '0;
        dataPos <= '0;
      end else begin
        dataPos <= dataPos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (str.readStep)
      rdData <= readValid ? readWord : '0;
  end

  p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    str.clrAll |=> (cmdPos == '0 && dataPos == '0));
  p_rewind_r4: assert property (@(posedge clk) disable iff (!rstN)
    (str.rewind && !str.clrAll) |=> dataPos == '0);
  p_cmd_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdPos <= CPOS_W'(CMD_W));
  p_read_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (str.readStep && readValid && !writeAny && !lastBit) |=> dataPos == $past(dataPos) + 1'b1);
  p_read_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    (str.readStep && readValid && !writeAny && lastBit) |=> (cmdPos == '0 && dataPos == '0));
  p_idle_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (str.readStep && !readValid && !writeAny) |=>
      (rdData == '0 && $stable(cmdPos) && $stable(dataPos) && $stable(cmdWord)));
endmodule

// File: rtl/dual_thermo_serial.sv
module dual_thermo_serial
  import thermo_pkg::*;
#(
  parameter int SENSORS   = 2,
  parameter int RD_W      = 8,
  parameter int CMD_W     = 8,
  parameter int CFG_LEN   = 8,
  parameter int TEMP_LEN  = 9,
  parameter int TEMP_INIT = 44,
  parameter int CFG_INIT  = 8'h8A
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            wrAddr,
  input  logic [7:0]      wrData,
  input  logic            rdEn,
  output logic [RD_W-1:0] rdData
);
  strobe_t str;

  thermo_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdEn   (rdEn),
    .str    (str)
  );

  thermo_dp #(
    .SENSORS   (SENSORS),
    .RD_W      (RD_W),
    .CMD_W     (CMD_W),
    .CFG_LEN   (CFG_LEN),
    .TEMP_LEN  (TEMP_LEN),
    .TEMP_INIT (TEMP_INIT),
    .CFG_INIT  (CFG_INIT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .str    (str),
    .rdData (rdData)
  );

  initial begin
    assert (SENSORS <= RD_W);
  end
endmodule

// File: tb/dual_thermo_serial_bench.sv
module dual_thermo_serial_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_thermo_serial u_dual_thermo_serial (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData)
  );

  // scenario table: command, number of reads, register pattern, read length
  localparam logic [24:0] SCEN [5] = '{
    {8'hAA, 4'd10, 9'h02C, 4'd9},
    {8'hAC, 4'd9,  9'h08A, 4'd8},
    {8'hEE, 4'd2,  9'h000, 4'd0},
    {8'h55, 4'd2,  9'h000, 4'd0},
    {8'hAA, 4'd10, 9'h02C, 4'd9}
  };

  task automatic cyc(input logic doRd, input logic doWr, input logic addr, input logic [7:0] d);
    @(negedge clk);
    rdEn = doRd; wrEn = doWr; wrAddr = addr; wrData = d;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, 1'b1, c[i] ? 8'h01 : 8'h00);
  endtask

  task automatic readChk(input logic [7:0] exp, input string tag);
    cyc(1'b1, 1'b0, 1'b0, 8'h00);
    check(rdData, exp, tag);
  endtask

  function automatic logic [7:0] pair(input logic b);
    return {6'b0, b, b};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData, 8'h00, "R1 reset output");
    // R1/R3: flag clear after reset, command bits ignored
    sendCmd(8'hAA);
    readChk(8'h00, "R1 no command before clock-low");
    // R3: clock-low then a full command is accepted
    cyc(1'b0, 1'b1, 1'b0, 8'h02);
    sendCmd(8'hAA);
    readChk(pair(1'b0), "R3 pos0");
    readChk(pair(1'b0), "R3 pos1");
    readChk(pair(1'b1), "R3 pos2");

    // table walk: R5 R6 R8 R9 R10 R11
    for (int s = 0; s < 5; s++) begin
      logic [7:0] c; logic [3:0] n; logic [8:0] pat; logic [3:0] len;
      {c, n, pat, len} = SCEN[s];
      cyc(1'b0, 1'b1, 1'b0, 8'h04);
      sendCmd(c);
      for (int k = 0; k < 16; k++) begin
        if (k < int'(n))
          readChk((k < int'(len)) ? pair(pat[k]) : 8'h00, "R8 R9 R11 scenario read");
      end
    end

    // R3: clock-high makes shifted bits ignored, then clock-low accepts them
    cyc(1'b0, 1'b1, 1'b0, 8'h04);
    cyc(1'b0, 1'b1, 1'b0, 8'h01);
    sendCmd(8'hAA);
    cyc(1'b0, 1'b1, 1'b0, 8'h02);
    sendCmd(8'hAA);
    readChk(pair(1'b0), "R3 gated pos0");
    readChk(pair(1'b0), "R3 gated pos1");
    readChk(pair(1'b1), "R3 gated pos2");

    // R4: enable-read rewinds even with clock high
    cyc(1'b0, 1'b1, 1'b0, 8'h01);
    cyc(1'b0, 1'b1, 1'b1, 8'h80);
    readChk(pair(1'b0), "R4 rewind pos0");
    readChk(pair(1'b0), "R4 rewind pos1");
    readChk(pair(1'b1), "R4 rewind pos2");

    // R7: data writes after command advance position
    cyc(1'b0, 1'b1, 1'b0, 8'h02);
    cyc(1'b0, 1'b1, 1'b0, 8'h04);
    sendCmd(8'hAA);
    cyc(1'b0, 1'b1, 1'b1, 8'h01);
    cyc(1'b0, 1'b1, 1'b1, 8'h00);
    readChk(pair(1'b1), "R7 pos2 after two data writes");
    readChk(pair(1'b1), "R7 pos3");
    readChk(pair(1'b0), "R7 pos4");
    readChk(pair(1'b1), "R7 pos5");

    // R2: reset-on in the middle of a command
    cyc(1'b0, 1'b1, 1'b0, 8'h04);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b1, 8'h01);
    cyc(1'b0, 1'b1, 1'b0, 8'h04);
    sendCmd(8'hAA);
    readChk(pair(1'b0), "R2 pos0 after mid reset");
    readChk(pair(1'b0), "R2 pos1");
    readChk(pair(1'b1), "R2 pos2");

    // R12: read and enable-read in the same cycle
    cyc(1'b0, 1'b1, 1'b0, 8'h04);
    sendCmd(8'hAA);
    readChk(pair(1'b0), "R12 pos0");
    readChk(pair(1'b0), "R12 pos1");
    cyc(1'b1, 1'b1, 1'b1, 8'h80);
    check(rdData, pair(1'b1), "R12 read sees old pos2");
    readChk(pair(1'b0), "R12 rewound pos0");
    readChk(pair(1'b0), "R12 rewound pos1");
    readChk(pair(1'b1), "R12 rewound pos2");

    // R10: read with no command held returns zero, state untouched
    cyc(1'b0, 1'b1, 1'b0, 8'h04);
    readChk(8'h00, "R10 idle read");
    sendCmd(8'hAC);
    readChk(pair(1'b0), "R10 config pos0 after idle read");
    readChk(pair(1'b1), "R10 config pos1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule